// File: doc/BRIEF.md
# Four-Channel Prioritised DMA Transfer Sequencer

This block moves single data words between memory regions on behalf of four channels. Each channel holds a source address, a destination address and a remaining-transfer count, loaded through a simple load port. A pulse on a channel's request input asks for one transfer. A fixed-priority arbiter picks the winning channel. The sequencer then waits a fixed response time, reads the source word, idles one clock and writes the word to the destination.

Every bus access lasts a number of clocks set by the memory region its address falls in. The region is the top two address bits. The peripheral region adds a programmable wait count. The block drives a read or write strobe for the whole access and marks the final clock of each access with a last flag. It captures read data on the last read clock. Priority is decided again before every transfer, so a higher-priority request can step in between two transfers of a lower channel. When a channel's count runs out, the channel raises its done flag and stops taking requests.

Top module: `dma4_seq`

## Requirements
- R1: Arbitration uses a fixed priority in which channel 0 beats channel 1, channel 1 beats channel 2 and channel 2 beats channel 3. `act_ch` shows the granted channel while `xfer_busy` is high.
- R2: Arbitration takes place at a rising edge where the sequencer is idle, and also at the edge that ends the final write clock of a transfer. A higher-priority request that is pending at that point wins over a further pending request of the channel that just finished.
- R3: After the grant edge, `xfer_busy` is high with no access for exactly 4 clocks. `bus_rd` first rises after the fourth rising edge that follows the grant.
- R4: The access length in clocks comes from address bits [AW-1:AW-2]: 00 gives 2, 01 gives 3 plus `per_wait`, and 10 or 11 give 4. `bus_last` is high on the final clock of every access.
- R5: Exactly one clock with neither strobe high separates the last read clock from the first write clock. A transfer therefore lasts 4 + read length + 1 + write length clocks, counted from the grant edge.
- R6: `bus_addr` carries the channel's source address during the read and its destination address during the write, and is 0 otherwise. `bus_wdata` carries the word sampled from `bus_rdata` on the last read clock, for the whole write, and is 0 otherwise.
- R7: After each completed write, the channel adds STEP to its source and destination addresses and subtracts one from its count. When the count reaches zero, `done` for that channel goes high, and later requests to that channel are ignored and start no transfer.
- R8: A request pulse is held pending until its channel is granted. Each grant performs one transfer. A pulse that arrives while another transfer is running is kept.
- R9: `ld_en` loads the source address, destination address and count of channel `ld_ch`, and clears that channel's done flag and pending request. A load aimed at the channel whose transfer is in progress is ignored, and `done` falls only on a load.
- R10: After reset the sequencer is idle: no strobes, `bus_addr` 0, `bus_wdata` 0, `done` all 0.
- R11: `bus_rd` and `bus_wr` are never high in the same clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| per_wait | input | 2 | Extra wait clocks for peripheral-region accesses |
| ld_en | input | 1 | Load strobe for channel settings |
| ld_ch | input | $clog2(NCH) | Channel selected by the load |
| ld_src | input | AW | Source address to load |
| ld_dst | input | AW | Destination address to load |
| ld_cnt | input | CW | Transfer count to load |
| req | input | NCH | Per-channel transfer request pulses |
| bus_rd | output | 1 | Read access in progress |
| bus_wr | output | 1 | Write access in progress |
| bus_last | output | 1 | Final clock of the current access |
| bus_addr | output | AW | Access address |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data from memory |
| xfer_busy | output | 1 | A transfer is in progress |
| act_ch | output | $clog2(NCH) | Channel owning the current transfer |
| done | output | NCH | Per-channel count-exhausted flags |

## Verification
The bench builds the block with its default parameters: four channels, 16-bit addresses and data, 8-bit counts and an address step of 2. With these values the two-bit region field sits at address bits 15:14, so the bench can place source and destination in every one of the four regions. It runs all sixteen region pairs under every `per_wait` value. The 8-bit count lets a channel carry several transfers, which brings within reach preemption between transfers, exhaustion of the count and loads that arrive mid-transfer.

// File: rtl/dma4_pkg.sv
package dma4_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RESP,
        ST_RD,
        ST_GAP,
        ST_WR
    } seq_st_e;

    typedef enum logic [1:0] {
        RG_IRAM = 2'b00,
        RG_PERI = 2'b01,
        RG_DEVR = 2'b10,
        RG_DRAM = 2'b11
    } region_e;

    localparam int RESP_CLKS     = 4;
    localparam int LAT_IRAM      = 2;
    localparam int LAT_PERI_BASE = 3;
    localparam int LAT_WIDE      = 4;

    // Clock count of one access, from its region and the peripheral wait setting
    function automatic logic [2:0] access_len(input logic [1:0] rg, input logic [1:0] wt);
        logic [2:0] n;
        case (region_e'(rg))
            RG_IRAM: n = 3'(LAT_IRAM);
            RG_PERI: n = 3'(LAT_PERI_BASE) + {1'b0, wt};
            default: n = 3'(LAT_WIDE);
        endcase
        return n;
    endfunction

endpackage

// File: rtl/dma4_prio.sv
module dma4_prio #(
    parameter int NCH = 4,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH-1:0] elig,
    output logic [NCH-1:0] gnt,
    output logic           valid,
    output logic [CHW-1:0] idx
);

    // Lowest index wins
    for (genvar i = 0; i < NCH; i++) begin : g_pick
        if (i == 0) begin : g_first
            assign gnt[i] = elig[i];
        end else begin : g_rest
            assign gnt[i] = elig[i] & ~(|elig[i-1:0]);
        end
    end

    assign valid = |elig;

    always_comb begin
        idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (elig[i]) idx = CHW'(i);
        end
    end

endmodule

// File: rtl/dma4_chan.sv
module dma4_chan #(
    parameter int AW   = 16,
    parameter int CW   = 8,
    parameter int STEP = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld,
    input  logic [AW-1:0] ld_src,
    input  logic [AW-1:0] ld_dst,
    input  logic [CW-1:0] ld_cnt,
    input  logic          req,
    input  logic          active,
    input  logic          wr_done,
    input  logic          granted,
    output logic [AW-1:0] src,
    output logic [AW-1:0] dst,
    output logic          elig,
    output logic          done
);

    logic [CW-1:0] cnt;
    logic          pend;
    logic          ld_ok;
    logic          cnt_ok;

    assign ld_ok  = ld & ~active;
    // Count as it stands after this edge: a finishing write takes one away
    assign cnt_ok = wr_done ? (cnt != CW'(1)) : (cnt != '0);
    assign elig   = ~ld_ok & (pend | req) & cnt_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            src  <= '0;
            dst  <= '0;
            cnt  <= '0;
            pend <= 1'b0;
            done <= 1'b0;
        end else if (ld_ok) begin
            src  <= ld_src;
            dst  <= ld_dst;
            cnt  <= ld_cnt;
            pend <= 1'b0;
            done <= 1'b0;
        end else begin
            if (wr_done) begin
                src <= src + AW'(STEP);
                dst <= dst + AW'(STEP);
                cnt <= cnt - CW'(1);
                if (cnt == CW'(1)) done <= 1'b1;
            end
            pend <= (pend | (req & cnt_ok)) & ~granted;
        end
    end

endmodule

// File: rtl/dma4_timer.sv
module dma4_timer
    import dma4_pkg::*;
#(
    parameter int AW  = 16,
    parameter int DW  = 16,
    parameter int CHW = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           arb_valid,
    input  logic [CHW-1:0] arb_idx,
    input  logic [AW-1:0]  src_addr,
    input  logic [AW-1:0]  dst_addr,
    input  logic [1:0]     per_wait,
    input  logic [DW-1:0]  bus_rdata,
    output logic           arb_pt,
    output logic           wr_last,
    output logic           busy,
    output logic [CHW-1:0] cur_ch,
    output logic           bus_rd,
    output logic           bus_wr,
    output logic           bus_last,
    output logic [AW-1:0]  bus_addr,
    output logic [DW-1:0]  bus_wdata
);

    seq_st_e       st;
    logic [2:0]    ctr;
    logic [DW-1:0] dat;
    logic [2:0]    rd_len;
    logic [2:0]    wr_len;

    assign rd_len  = access_len(src_addr[AW-1 -: 2], per_wait);
    assign wr_len  = access_len(dst_addr[AW-1 -: 2], per_wait);
    assign wr_last = (st == ST_WR) && (ctr == '0);
    assign arb_pt  = (st == ST_IDLE) || wr_last;
    assign busy    = (st != ST_IDLE);

    assign bus_rd    = (st == ST_RD);
    assign bus_wr    = (st == ST_WR);
    assign bus_last  = (bus_rd || bus_wr) && (ctr == '0);
    assign bus_addr  = bus_rd ? src_addr : (bus_wr ? dst_addr : '0);
    assign bus_wdata = bus_wr ? dat : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            ctr    <= '0;
            cur_ch <= '0;
            dat    <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (arb_valid) begin
                        st     <= ST_RESP;
                        ctr    <= 3'(RESP_CLKS - 1);
                        cur_ch <= arb_idx;
                    end
                end
                ST_RESP: begin
                    if (ctr == '0) begin
                        st  <= ST_RD;
                        ctr <= rd_len - 3'd1;
                    end else begin
                        ctr <= ctr - 3'd1;
                    end
                end
                ST_RD: begin
                    if (ctr == '0) begin
                        st  <= ST_GAP;
                        dat <= bus_rdata;
                    end else begin
                        ctr <= ctr - 3'd1;
                    end
                end
                ST_GAP: begin
                    st  <= ST_WR;
                    ctr <= wr_len - 3'd1;
                end
                ST_WR: begin
                    if (ctr == '0) begin
                        if (arb_valid) begin
                            st     <= ST_RESP;
                            ctr    <= 3'(RESP_CLKS - 1);
                            cur_ch <= arb_idx;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end else begin
                        ctr <= ctr - 3'd1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dma4_seq.sv
module dma4_seq
    import dma4_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int AW   = 16,
    parameter int DW   = 16,
    parameter int CW   = 8,
    parameter int STEP = 2,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [1:0]     per_wait,
    input  logic           ld_en,
    input  logic [CHW-1:0] ld_ch,
    input  logic [AW-1:0]  ld_src,
    input  logic [AW-1:0]  ld_dst,
    input  logic [CW-1:0]  ld_cnt,
    input  logic [NCH-1:0] req,
    output logic           bus_rd,
    output logic           bus_wr,
    output logic           bus_last,
    output logic [AW-1:0]  bus_addr,
    output logic [DW-1:0]  bus_wdata,
    input  logic [DW-1:0]  bus_rdata,
    output logic           xfer_busy,
    output logic [CHW-1:0] act_ch,
    output logic [NCH-1:0] done
);

    logic [NCH-1:0] elig;
    logic [NCH-1:0] gnt;
    logic           arb_valid_raw;
    logic           arb_valid;
    logic [CHW-1:0] arb_idx;
    logic           arb_pt;
    logic           wr_last;
    logic           busy;
    logic [CHW-1:0] cur_ch;
    logic [AW-1:0]  ch_src [NCH];
    logic [AW-1:0]  ch_dst [NCH];

    dma4_prio #(.NCH(NCH)) u_prio (
        .elig  (elig),
        .gnt   (gnt),
        .valid (arb_valid_raw),
        .idx   (arb_idx)
    );

    assign arb_valid = arb_valid_raw & arb_pt;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic is_cur;
        assign is_cur = busy && (cur_ch == CHW'(i));

        dma4_chan #(.AW(AW), .CW(CW), .STEP(STEP)) u_chan (
            .clk     (clk),
            .rst     (rst),
            .ld      (ld_en && (ld_ch == CHW'(i))),
            .ld_src  (ld_src),
            .ld_dst  (ld_dst),
            .ld_cnt  (ld_cnt),
            .req     (req[i]),
            .active  (is_cur),
            .wr_done (is_cur && wr_last),
            .granted (arb_valid && gnt[i]),
            .src     (ch_src[i]),
            .dst     (ch_dst[i]),
            .elig    (elig[i]),
            .done    (done[i])
        );
    end

    dma4_timer #(.AW(AW), .DW(DW), .CHW(CHW)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .arb_valid (arb_valid),
        .arb_idx   (arb_idx),
        .src_addr  (ch_src[cur_ch]),
        .dst_addr  (ch_dst[cur_ch]),
        .per_wait  (per_wait),
        .bus_rdata (bus_rdata),
        .arb_pt    (arb_pt),
        .wr_last   (wr_last),
        .busy      (busy),
        .cur_ch    (cur_ch),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_last  (bus_last),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata)
    );

    assign xfer_busy = busy;
    assign act_ch    = cur_ch;

endmodule

// File: rtl/dma4_seq_chk.sv
module dma4_seq_chk #(
    parameter int NCH = 4,
    parameter int AW  = 16
) (
    input logic           clk,
    input logic           rst,
    input logic           bus_rd,
    input logic           bus_wr,
    input logic           bus_last,
    input logic [AW-1:0]  bus_addr,
    input logic           xfer_busy,
    input logic [NCH-1:0] done,
    input logic           ld_en
);

    p_excl_r11: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && bus_wr));

    p_gap_idle_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_last) |=> (!bus_rd && !bus_wr));

    p_gap_then_write_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_last) |-> ##2 bus_wr);

    p_iram_len_r4: assert property (@(posedge clk) disable iff (rst)
        ($rose(bus_rd) && bus_addr[AW-1 -: 2] == 2'b00) |-> !bus_last ##1 bus_last);

    p_wide_len_r4: assert property (@(posedge clk) disable iff (rst)
        ($rose(bus_rd) && bus_addr[AW-1]) |-> !bus_last ##1 !bus_last ##1 !bus_last ##1 bus_last);

    p_addr_hold_r6: assert property (@(posedge clk) disable iff (rst)
        ((bus_rd || bus_wr) && !bus_last) |=> $stable(bus_addr));

    p_resp_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(xfer_busy) |-> !bus_rd ##1 !bus_rd ##1 !bus_rd ##1 !bus_rd ##1 bus_rd);

    p_done_fall_r9: assert property (@(posedge clk) disable iff (rst)
        (|($past(done) & ~done)) |-> $past(ld_en));

endmodule

bind dma4_seq dma4_seq_chk #(.NCH(NCH), .AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_last  (bus_last),
    .bus_addr  (bus_addr),
    .xfer_busy (xfer_busy),
    .done      (done),
    .ld_en     (ld_en)
);

// File: tb/sim_dma4_seq.sv
module sim_dma4_seq;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  per_wait;
    logic        ld_en;
    logic [1:0]  ld_ch;
    logic [15:0] ld_src;
    logic [15:0] ld_dst;
    logic [7:0]  ld_cnt;
    logic [3:0]  req;
    logic        bus_rd, bus_wr, bus_last, xfer_busy;
    logic [15:0] bus_addr, bus_wdata, bus_rdata;
    logic [1:0]  act_ch;
    logic [3:0]  done;

    int vectors = 0;
    int miscompares = 0;

    always #5 clk = ~clk;

    function automatic logic [15:0] memf(input logic [15:0] a);
        return (a * 16'd3) ^ 16'h5A5A;
    endfunction

    assign bus_rdata = memf(bus_addr);

    dma4_seq u0 (
        .clk(clk), .rst(rst), .per_wait(per_wait), .ld_en(ld_en), .ld_ch(ld_ch),
        .ld_src(ld_src), .ld_dst(ld_dst), .ld_cnt(ld_cnt), .req(req),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_last(bus_last), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .xfer_busy(xfer_busy),
        .act_ch(act_ch), .done(done)
    );

    // Behavioural reference state
    int m_src[4], m_dst[4], m_cnt[4];
    bit m_pend[4], m_done[4];
    bit m_busy;
    int m_t, m_R, m_W, m_ch, m_wd;
    int order_q[$];
    int raddr_q[$];
    bit prev_rd;

    function automatic int lat(input int a, input int w);
        case ((a >> 14) & 3)
            0: return 2;
            1: return 3 + w;
            default: return 4;
        endcase
    endfunction

    task automatic chk(input int act, input int exp, input string tag);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic bit any_pend();
        return m_pend[0] || m_pend[1] || m_pend[2] || m_pend[3];
    endfunction

    task automatic model_edge();
        bit wl, arb, act, ldok;
        int g;
        int ca[4];
        bit el[4];
        wl  = m_busy && (m_t == 4 + m_R + m_W);
        arb = !m_busy || wl;
        for (int i = 0; i < 4; i++) begin
            act   = m_busy && (m_ch == i);
            ca[i] = (wl && m_ch == i) ? m_cnt[i] - 1 : m_cnt[i];
            ldok  = ld_en && (int'(ld_ch) == i) && !act;
            el[i] = !ldok && (m_pend[i] || req[i]) && (ca[i] != 0);
        end
        g = -1;
        if (arb) for (int i = 3; i >= 0; i--) if (el[i]) g = i;
        for (int i = 0; i < 4; i++) begin
            act  = m_busy && (m_ch == i);
            ldok = ld_en && (int'(ld_ch) == i) && !act;
            if (ldok) begin
                m_src[i] = int'(ld_src); m_dst[i] = int'(ld_dst); m_cnt[i] = int'(ld_cnt);
                m_pend[i] = 0; m_done[i] = 0;
            end else begin
                if (wl && m_ch == i) begin
                    m_src[i] = (m_src[i] + 2) & 16'hFFFF;
                    m_dst[i] = (m_dst[i] + 2) & 16'hFFFF;
                    m_cnt[i] = ca[i];
                    if (ca[i] == 0) m_done[i] = 1;
                end
                m_pend[i] = (m_pend[i] || (req[i] && ca[i] != 0)) && (g != i);
            end
        end
        if (g >= 0) begin
            m_busy = 1; m_t = 0; m_ch = g;
            m_R = lat(m_src[g], int'(per_wait));
            m_W = lat(m_dst[g], int'(per_wait));
            m_wd = int'(memf(16'(m_src[g])));
        end else if (wl) begin
            m_busy = 0;
        end else if (m_busy) begin
            m_t++;
        end
    endtask

    task automatic compare();
        int er, ew, el, ea, ed;
        er = (m_busy && m_t >= 4 && m_t < 4 + m_R) ? 1 : 0;
        ew = (m_busy && m_t >= 5 + m_R && m_t <= 4 + m_R + m_W) ? 1 : 0;
        el = (m_busy && (m_t == 3 + m_R || m_t == 4 + m_R + m_W)) ? 1 : 0;
        ea = (er != 0) ? m_src[m_ch] : ((ew != 0) ? m_dst[m_ch] : 0);
        ed = (ew != 0) ? m_wd : 0;
        chk(int'(xfer_busy), int'(m_busy), "R3 busy/response");
        chk(int'(bus_rd), er, "R5 read strobe");
        chk(int'(bus_wr), ew, "R5 write strobe");
        chk(int'(bus_last), el, "R4 last flag");
        chk(int'(bus_addr), ea, "R6 address");
        chk(int'(bus_wdata), ed, "R6 write data");
        chk(int'(bus_rd && bus_wr), 0, "R11 strobe overlap");
        if (m_busy) chk(int'(act_ch), m_ch, "R1 active channel");
        for (int i = 0; i < 4; i++) chk(int'(done[i]), int'(m_done[i]), "R7 done flag");
        if (bus_rd && !prev_rd) begin
            order_q.push_back(int'(act_ch));
            raddr_q.push_back(int'(bus_addr));
        end
        prev_rd = bus_rd;
    endtask

    task automatic tick();
        model_edge();
        @(negedge clk);
        req   = '0;
        ld_en = 1'b0;
        compare();
    endtask

    task automatic load(input int ch, input int s, input int d, input int c);
        ld_en = 1'b1; ld_ch = 2'(ch); ld_src = 16'(s); ld_dst = 16'(d); ld_cnt = 8'(c);
        tick();
    endtask

    task automatic run_idle();
        int g = 0;
        while ((m_busy || any_pend()) && g < 400) begin
            tick();
            g++;
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; per_wait = 2'd0; ld_en = 1'b0; ld_ch = '0;
        ld_src = '0; ld_dst = '0; ld_cnt = '0; req = '0;
        for (int i = 0; i < 4; i++) begin
            m_src[i] = 0; m_dst[i] = 0; m_cnt[i] = 0; m_pend[i] = 0; m_done[i] = 0;
        end
        m_busy = 0; m_t = 0; m_R = 0; m_W = 0; m_ch = 0; m_wd = 0; prev_rd = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R10: reset state
        chk(int'(bus_rd), 0, "R10 bus_rd after reset");
        chk(int'(bus_wr), 0, "R10 bus_wr after reset");
        chk(int'(xfer_busy), 0, "R10 busy after reset");
        chk(int'(bus_addr), 0, "R10 addr after reset");
        chk(int'(bus_wdata), 0, "R10 wdata after reset");
        chk(int'(done), 0, "R10 done after reset");

        // R1: simultaneous requests
        for (int i = 0; i < 4; i++) load(i, 16'h0040 + i * 16, 16'h0080 + i * 16, 1);
        order_q.delete();
        req = 4'hF;
        tick();
        run_idle();
        chk(order_q.size(), 4, "R1 grant count");
        for (int i = 0; i < 4 && i < order_q.size(); i++) chk(order_q[i], i, "R1 grant order");

        // R2: preemption between transfers of a lower channel
        load(3, 16'h0100, 16'h0200, 4);
        load(1, 16'h0300, 16'h0400, 4);
        order_q.delete();
        req = 4'b1000;
        tick();
        repeat (3) tick();
        req = 4'b1010;
        tick();
        run_idle();
        chk(order_q.size(), 3, "R2 grant count");
        if (order_q.size() == 3) begin
            chk(order_q[0], 3, "R2 first grant");
            chk(order_q[1], 1, "R2 preempting grant");
            chk(order_q[2], 3, "R2 resumed grant");
        end

        // R8: request during another transfer is held
        load(0, 16'h0500, 16'h0600, 2);
        load(2, 16'h0700, 16'h0800, 2);
        order_q.delete();
        req = 4'b0001;
        tick();
        repeat (2) tick();
        req = 4'b0100;
        tick();
        run_idle();
        chk(order_q.size(), 2, "R8 grant count");
        if (order_q.size() == 2) chk(order_q[1], 2, "R8 held request served");

        // R3 R4 R5 R6: every region pair under every wait setting
        for (int w = 0; w < 4; w++) begin
            per_wait = 2'(w);
            for (int s = 0; s < 4; s++) begin
                for (int d = 0; d < 4; d++) begin
                    int n, rdc, first_rd;
                    int sa, da;
                    sa = (s << 14) | 16'h0010;
                    da = (d << 14) | 16'h0020;
                    load(2, sa, da, 1);
                    n = 0; rdc = 0; first_rd = 0;
                    req = 4'b0100;
                    do begin
                        tick();
                        n++;
                        if (bus_rd) begin
                            rdc++;
                            if (first_rd == 0) first_rd = n;
                        end
                        if (bus_wr && bus_last)
                            chk(int'(bus_wdata), int'(memf(16'(sa))), "R6 written word");
                    end while (!(bus_wr && bus_last) && n < 50);
                    chk(first_rd, 5, "R3 response clocks");
                    chk(rdc, lat(sa, w), "R4 read length");
                    chk(n, 4 + lat(sa, w) + 1 + lat(da, w), "R5 transfer length");
                    tick();
                end
            end
        end
        per_wait = 2'd0;

        // R7: count exhaustion and address stepping
        load(1, 16'h4000, 16'h8000, 2);
        raddr_q.delete();
        req = 4'b0010; tick(); run_idle();
        req = 4'b0010; tick(); run_idle();
        chk(int'(done[1]), 1, "R7 done after last transfer");
        if (raddr_q.size() == 2) chk(raddr_q[1], 16'h4002, "R7 source step");
        else chk(raddr_q.size(), 2, "R7 transfer count");
        req = 4'b0010;
        tick();
        repeat (5) tick();
        chk(int'(xfer_busy), 0, "R7 request ignored when exhausted");

        // R9: load to the active channel is ignored, load clears done
        load(0, 16'h0300, 16'hC000, 3);
        req = 4'b0001;
        tick();
        tick();
        load(0, 16'h0900, 16'h0A00, 5);
        run_idle();
        raddr_q.delete();
        req = 4'b0001;
        tick();
        run_idle();
        if (raddr_q.size() == 1) chk(raddr_q[0], 16'h0302, "R9 active-channel load ignored");
        else chk(raddr_q.size(), 1, "R9 transfer count");
        load(1, 16'h0000, 16'h0010, 1);
        chk(int'(done[1]), 0, "R9 load clears done");

        repeat (3) tick();
        finish_run();
    end

endmodule